// File: doc/BRIEF.md
# Multi-Select Byte-Wide Static RAM

A 128-location, 8-bit random-access memory meant to sit on a simple 8-bit processor bus. The chip answers only when six select inputs are all at their active levels. Four of them are active low and two are active high, so that address-decode terms of either polarity can be wired straight in. A read/write line picks the direction of the transfer. When it is high and the chip is selected, the addressed byte is driven onto the bus. When it is low, the byte on the bus is stored when the combined select pulse ends.

The bidirectional bus pin is split into a data input, a data output and an output enable. The enable is raised only during a selected read, so the pad stays high-impedance at every other time. A fast internal clock samples the select, direction, address and data inputs. A write commits on the first sample that sees the combined select inactive after it was active. It uses the address and data held on the last sample in which the select was still active. The read path is combinational from the address, so moving the address during a selected read shows the new byte.

Top module: `byte_ram_top`

## Requirements
- R1: The chip counts as selected only when all four bits of `selLowN` are 0 and both bits of `selHigh` are 1. Any single select at its inactive level deselects it, and a write pulse made under that condition stores nothing.
- R2: `dataOe` is 1 exactly when the chip is selected and `rnw` is 1. It is 0 at every other time, including straight after reset.
- R3: While `dataOe` is 1, `dataOut` equals the byte stored at `addr` and follows changes of `addr` within the same cycle. While `dataOe` is 0, `dataOut` is 0.
- R4: A write (`rnw` = 0) commits on the first rising clock edge that samples the combined select inactive after it was sampled active. From that edge on, the stored byte is visible to reads.
- R5: The committed address and data are those sampled on the last rising edge at which the select was still active. Data that changes within the pulse is therefore stored as its final value.
- R6: If `rnw` is 1 on the last active sample of a select pulse, the end of the pulse stores nothing.
- R7: While `rst` is 1 the edge-detect state is cleared, so a pulse that ends during or just after reset stores nothing. Reset does not alter stored bytes.
- R8: All 128 addresses (0x00 to 0x7F) hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset of the edge-detect state |
| addr | input | 7 | Byte address |
| dataIn | input | 8 | Byte from the bus (write data) |
| dataOut | output | 8 | Byte to the bus (read data, 0 when not enabled) |
| dataOe | output | 1 | Bus drive enable, high only during a selected read |
| rnw | input | 1 | 1 = read, 0 = write |
| selLowN | input | 4 | Four active-low chip selects |
| selHigh | input | 2 | Two active-high chip selects |

## Verification
The bench goes after each of the six selects singly inactive. A combiner that treats one polarity wrongly, or that ORs the selects, would drive the bus or store a byte there. It moves the data in the middle of a write pulse and checks that only the final value is stored, which catches a design that commits on the leading edge or latches the first sample. It also ends a pulse with the direction line high, and ends another during reset. A design that ignores the direction or keeps edge state across reset would then corrupt a location. A full fill and readback of all 128 addresses exposes address-bit swaps or aliasing.

// File: rtl/byte_ram_pkg.sv
package byte_ram_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int LOW_SELS = 4;
  localparam int HIGH_SELS = 2;

  typedef struct packed {
    logic wrEn;
    logic rdOe;
  } ramStrobes_t;
endpackage

// File: rtl/ram_select_combine.sv
module ram_select_combine #(
  parameter int LOW_N = 4,
  parameter int HIGH_N = 2
) (
  input  logic [LOW_N-1:0]  selLowN,
  input  logic [HIGH_N-1:0] selHigh,
  output logic              selActive
);
  localparam int TOTAL = LOW_N + HIGH_N;
  logic [TOTAL-1:0] termOk;

  genvar gi;
  generate
    for (gi = 0; gi < LOW_N; gi++) begin : g_low
      assign termOk[gi] = ~selLowN[gi];
    end
    for (gi = 0; gi < HIGH_N; gi++) begin : g_high
      assign termOk[LOW_N+gi] = selHigh[gi];
    end
  endgenerate

  assign selActive = &termOk;
endmodule

// File: rtl/ram_ctrl.sv
module ram_ctrl
  import byte_ram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          selActive,
  input  logic          rnw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dataIn,
  output ramStrobes_t   strobes,
  output logic [AW-1:0] capAddr,
  output logic [DW-1:0] capData
);
  logic selPrev;
  logic capRnw;

  always_ff @(posedge clk) begin
    if (rst) begin
      selPrev <= 1'b0;
      capRnw  <= 1'b1;
    end else begin
      selPrev <= selActive;
      if (selActive) capRnw <= rnw;
    end
  end

  always_ff @(posedge clk) begin
    if (selActive) begin
      capAddr <= addr;
      capData <= dataIn;
    end
  end

  always_comb begin
    strobes.rdOe = selActive & rnw;
    strobes.wrEn = ~rst & selPrev & ~selActive & ~capRnw;
  end
endmodule

// File: rtl/ram_datapath.sv
module ram_datapath
  import byte_ram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  ramStrobes_t   strobes,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= wrData;
  end

  always_comb begin
    rdData = strobes.rdOe ? store[rdAddr] : '0;
  end
endmodule

// File: rtl/byte_ram_top.sv
module byte_ram_top
  import byte_ram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataOe,
  input  logic                 rnw,
  input  logic [LOW_SELS-1:0]  selLowN,
  input  logic [HIGH_SELS-1:0] selHigh
);
  logic              selActive;
  ramStrobes_t       strobes;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;

  ram_select_combine #(.LOW_N(LOW_SELS), .HIGH_N(HIGH_SELS)) combine_i (
    .selLowN(selLowN), .selHigh(selHigh), .selActive(selActive)
  );

  ram_ctrl #(.AW(ADDR_W), .DW(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .selActive(selActive), .rnw(rnw),
    .addr(addr), .dataIn(dataIn), .strobes(strobes),
    .capAddr(capAddr), .capData(capData)
  );

  ram_datapath #(.AW(ADDR_W), .DW(DATA_W)) dp_i (
    .clk(clk), .strobes(strobes), .wrAddr(capAddr), .wrData(capData),
    .rdAddr(addr), .rdData(dataOut)
  );

  assign dataOe = strobes.rdOe;
endmodule

// File: rtl/byte_ram_checker.sv
module byte_ram_checker
  import byte_ram_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 selActive,
  input logic                 wrEn,
  input logic                 rnw,
  input logic                 dataOe,
  input logic [DATA_W-1:0]    dataOut,
  input logic [LOW_SELS-1:0]  selLowN,
  input logic [HIGH_SELS-1:0] selHigh
);
  AST_OE_ALL_SELECTS: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> ((selLowN == '0) && (&selHigh))); // R1
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> rnw); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dataOe |-> (dataOut == '0)); // R3
  AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> ($past(selActive) && !selActive)); // R4
  AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> !$past(rnw)); // R6
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk)
    rst |-> !wrEn); // R7
endmodule

bind byte_ram_top byte_ram_checker chk_i (
  .clk(clk), .rst(rst), .selActive(selActive), .wrEn(strobes.wrEn),
  .rnw(rnw), .dataOe(dataOe), .dataOut(dataOut),
  .selLowN(selLowN), .selHigh(selHigh)
);

// File: tb/byte_ram_top_tb.sv
module byte_ram_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       rnw = 1'b1;
  logic [3:0] selLowN = 4'hF;
  logic [1:0] selHigh = 2'b00;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  byte_ram_top dut_i (
    .clk(clk), .rst(rst), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .rnw(rnw), .selLowN(selLowN), .selHigh(selHigh)
  );

  always #10 clk = ~clk;

  // Behavioural reference: stored bytes plus a "known" flag per address
  int  refMem [128];
  bit  refKnown [128];
  bit  mPrev = 0;
  int  mAddr = 0, mData = 0;
  bit  mRnw = 1;

  function automatic bit selNow();
    return (selLowN == 4'h0) && (selHigh == 2'b11);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPrev = 0;
    end else begin
      if (mPrev && !selNow() && !mRnw) begin
        refMem[mAddr] = mData;
        refKnown[mAddr] = 1;
      end
      mPrev = selNow();
    end
    if (selNow()) begin
      mAddr = addr;
      mData = dataIn;
      if (!rst) mRnw = rnw;
    end
    if (rst) mRnw = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R2, R3)
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit expOe;
      expOe = selNow() && rnw;
      chk("R2 per-cycle oe", int'(dataOe), int'(expOe));
      if (!expOe) chk("R3 per-cycle quiet", int'(dataOut), 0);
      else if (refKnown[addr]) chk("R3 per-cycle data", int'(dataOut), refMem[addr]);
    end
  end

  task automatic stepIn();
    @(posedge clk);
    #5;
  endtask

  task automatic selectAll();
    selLowN = 4'h0;
    selHigh = 2'b11;
  endtask

  task automatic deselect();
    selLowN = 4'hF;
    selHigh = 2'b00;
  endtask

  task automatic writeByte(input int a, input int d);
    stepIn();
    addr = 7'(a); dataIn = 8'(d); rnw = 1'b0; selectAll();
    stepIn();
    deselect();
    stepIn();
    rnw = 1'b1;
  endtask

  task automatic readCheck(input string req, input int a, input int exp);
    stepIn();
    addr = 7'(a); rnw = 1'b1; selectAll();
    @(negedge clk);
    chk(req, int'(dataOe), 1);
    chk(req, int'(dataOut), exp);
    stepIn();
    deselect();
  endtask

  function automatic int pat(input int a);
    return (a * 37 + 11) & 255;
  endfunction

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R2 reset oe", int'(dataOe), 0);
    chk("R3 reset out", int'(dataOut), 0);
    rst = 1'b0;

    // R8: fill all addresses, read back
    for (int a = 0; a < 128; a++) writeByte(a, pat(a));
    for (int a = 0; a < 128; a++) readCheck("R8 readback", a, pat(a));

    // R1: each single select inactive blocks reads and writes
    for (int k = 0; k < 6; k++) begin
      stepIn();
      addr = 7'd5; rnw = 1'b1; selectAll();
      if (k < 4) selLowN[k] = 1'b1; else selHigh[k-4] = 1'b0;
      @(negedge clk);
      chk("R1 read blocked oe", int'(dataOe), 0);
      chk("R1 read blocked out", int'(dataOut), 0);
      stepIn();
      addr = 7'd5; dataIn = 8'hEE; rnw = 1'b0;
      stepIn();
      deselect();
      stepIn();
      rnw = 1'b1;
      readCheck("R1 write blocked", 5, pat(5));
    end

    // R3: address moves while selected read
    stepIn();
    addr = 7'd10; rnw = 1'b1; selectAll();
    @(negedge clk);
    chk("R3 first addr", int'(dataOut), pat(10));
    #2 addr = 7'd99;
    #1 chk("R3 moved addr", int'(dataOut), pat(99));
    stepIn();
    deselect();

    // R4/R5: data changes mid-pulse, final value stored
    stepIn();
    addr = 7'd20; dataIn = 8'h11; rnw = 1'b0; selectAll();
    stepIn();
    dataIn = 8'h22;
    stepIn();
    dataIn = 8'h5A;
    stepIn();
    deselect(); dataIn = 8'hFF;
    stepIn();
    rnw = 1'b1;
    readCheck("R5 last sample data", 20, 8'h5A);
    // R4: stored byte visible right after the committing edge
    writeByte(21, 8'hC3);
    readCheck("R4 commit visible", 21, 8'hC3);

    // R6: pulse ending with rnw high stores nothing
    stepIn();
    addr = 7'd30; dataIn = 8'h00; rnw = 1'b1; selectAll();
    stepIn();
    deselect();
    stepIn();
    readCheck("R6 no write on read", 30, pat(30));

    // R7: pulse ends during reset -> no write; contents kept
    stepIn();
    addr = 7'd40; dataIn = 8'h77; rnw = 1'b0; selectAll();
    stepIn();
    rst = 1'b1;
    stepIn();
    deselect();
    stepIn();
    rst = 1'b0; rnw = 1'b1;
    stepIn();
    readCheck("R7 no write after reset", 40, pat(40));
    readCheck("R7 contents kept", 41, pat(41));

    done = 1;
    stepIn();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule